// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Single-Pin Event Interrupt

This block is a 16-pin general-purpose I/O port on a small word-wide register bus. A direction register and an output data register set up the pads. Each pad drives its output register bit whenever its direction bit is 0. Every pad input passes through a two-flop synchroniser, and software reads the synchronised levels from an input register. A clock-enable bit in the control register gates the synchroniser and the event logic. While that bit is 0, the sampled view of the pads stays frozen.

One pin at a time can raise an interrupt. Software picks it with a packed event-mode word that holds an enable bit, a pin index and an edge polarity. An edge on that pin sets a GPIO status bit, and reading the status register clears that bit. A second status bit records pulses from an external keypad-event input and stays set until software writes a 1 to it. A two-bit mask gates both status bits onto the single interrupt output. All registers are written as whole words, so software sets or clears single bits with read-modify-write.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset the registers hold these values: direction 0xFFFF, output data 0x0000, control 0x0000, event mode 0x0000, status 0x0000 and mask 0x0003. So `pad_oe` is 0x0000 and `irq_o` is 0.
- R2: For every pin i, `pad_oe[i]` is the inverse of direction bit i, so a direction bit of 1 makes the pin an input. `pad_out` equals the output data register. Both change on the clock edge that completes a write.
- R3: When control bit 5 (clock enable) is 1, the input register (address 2) returns `pad_in` delayed by two clock edges.
- R4: When control bit 5 is 0, the input register keeps its value and no GPIO event is detected, whatever `pad_in` does.
- R5: The event-mode register (address 4) uses bit 0 as the enable, bits 4:1 as the monitored pin index and bit 5 as the polarity (1 = rising, 0 = falling). When enabled, an edge of the selected polarity on the synchronised level of the selected pin sets status bit 1, and the bit is visible three edges after `pad_in` changes. Edges on other pins, edges of the other polarity, and edges while bit 0 is 0 set nothing.
- R6: A read of the status register (address 5) returns the value it held before that read, then clears status bit 1. If an event arrives in the same cycle as the read, bit 1 stays set.
- R7: A high cycle on `kpd_evt_i` sets status bit 0. That bit stays set through status reads and clears only when software writes the status register with bit 0 = 1. Writing bit 1 of the status register has no effect.
- R8: The mask register (address 6) has bit 0 for the keypad source and bit 1 for the GPIO source, and a 1 masks the source. `irq_o` is 1 exactly when a status bit is set and its mask bit is 0. A masked event still sets its status bit.
- R9: Writes replace the whole register. A read returns only the implemented bits: all 16 bits of direction and output data, bit 5 of control, bits 5:0 of event mode, and bits 1:0 of mask. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables, 1 = drive |
| kpd_evt_i | input | 1 | Keypad event pulse |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several rules on every cycle. After each direction write the output enables must match the inverse of the written word. The sampled inputs must not move while the clock enable is 0. A detected event must set the GPIO status bit, even when a status read lands in the same cycle. A status read with no event must clear that bit. The keypad bit must hold until a write-one clears it. Each rising edge of the interrupt must trace back to an event or a mask write. Only the bench's scenarios can show the exact input-to-register latency, the field decoding of the event-mode word, the rejection of the wrong pin or polarity, and the irq values produced by particular mask settings.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int NPIN  = 16;
    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int PIN_W = $clog2(NPIN);

    // register word addresses
    localparam logic [AW-1:0] A_DIR  = 3'd0;
    localparam logic [AW-1:0] A_OUT  = 3'd1;
    localparam logic [AW-1:0] A_IN   = 3'd2;
    localparam logic [AW-1:0] A_CTRL = 3'd3;
    localparam logic [AW-1:0] A_EVT  = 3'd4;
    localparam logic [AW-1:0] A_STAT = 3'd5;
    localparam logic [AW-1:0] A_MASK = 3'd6;

    localparam int CLKEN_BIT = 5;
    localparam int EV_EN_BIT = 0;
    localparam int EV_PIN_LO = 1;
    localparam int EV_RISE_BIT = EV_PIN_LO + PIN_W;

    // status / mask bit positions
    localparam int SRC_KPD  = 0;
    localparam int SRC_GPIO = 1;

    typedef struct packed {
        logic [NPIN-1:0]  dir;
        logic [NPIN-1:0]  dout;
        logic             clken;
        logic             ev_en;
        logic [PIN_W-1:0] ev_pin;
        logic             ev_rise;
        logic [1:0]       stat;
        logic [1:0]       mask;
    } regs_t;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else if (adv) begin
            st_q[0] <= din;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [W-1:0]  cur,
    input  logic          en,
    input  logic [SW-1:0] pin,
    input  logic          rise,
    output logic          hit
);
    logic [W-1:0] prev_q;
    logic         c_bit, p_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prev_q <= '0;
        else if (adv) prev_q <= cur;
    end

    always_comb begin
        c_bit = cur[pin];
        p_bit = prev_q[pin];
        hit   = adv && en && (rise ? (c_bit && !p_bit) : (!c_bit && p_bit));
    end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
    import gpio_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic          kpd_evt_i,
    output logic          irq_o
);
    regs_t r_q, r_d;
    logic [NPIN-1:0] in_sync;
    logic            evt_hit;
    logic            wr_en, rd_stat;

    gpio_evt_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (r_q.clken),
        .din  (pad_in),
        .dout (in_sync)
    );

    gpio_evt_edge #(.W(NPIN), .SW(PIN_W)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (r_q.clken),
        .cur  (in_sync),
        .en   (r_q.ev_en),
        .pin  (r_q.ev_pin),
        .rise (r_q.ev_rise),
        .hit  (evt_hit)
    );

    always_comb begin
        r_d     = r_q;
        wr_en   = bus_sel && bus_wr;
        rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);

        if (wr_en) begin
            case (bus_addr)
                A_DIR:  r_d.dir  = bus_wdata;
                A_OUT:  r_d.dout = bus_wdata;
                A_CTRL: r_d.clken = bus_wdata[CLKEN_BIT];
                A_EVT: begin
                    r_d.ev_en   = bus_wdata[EV_EN_BIT];
                    r_d.ev_pin  = bus_wdata[EV_PIN_LO +: PIN_W];
                    r_d.ev_rise = bus_wdata[EV_RISE_BIT];
                end
                A_STAT: if (bus_wdata[SRC_KPD]) r_d.stat[SRC_KPD] = 1'b0;
                A_MASK: r_d.mask = bus_wdata[1:0];
                default: ;
            endcase
        end

        // clear before set: a coincident event wins
        if (rd_stat)   r_d.stat[SRC_GPIO] = 1'b0;
        if (kpd_evt_i) r_d.stat[SRC_KPD]  = 1'b1;
        if (evt_hit)   r_d.stat[SRC_GPIO] = 1'b1;

        bus_rdata = '0;
        case (bus_addr)
            A_DIR:  bus_rdata = r_q.dir;
            A_OUT:  bus_rdata = r_q.dout;
            A_IN:   bus_rdata = in_sync;
            A_CTRL: bus_rdata[CLKEN_BIT] = r_q.clken;
            A_EVT: begin
                bus_rdata[EV_EN_BIT]            = r_q.ev_en;
                bus_rdata[EV_PIN_LO +: PIN_W]   = r_q.ev_pin;
                bus_rdata[EV_RISE_BIT]          = r_q.ev_rise;
            end
            A_STAT: bus_rdata[1:0] = r_q.stat;
            A_MASK: bus_rdata[1:0] = r_q.mask;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.dir    <= '1;
            r_q.mask   <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end

    assign pad_out = r_q.dout;
    assign pad_oe  = ~r_q.dir;
    assign irq_o   = |(r_q.stat & ~r_q.mask);
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] pad_oe,
    input logic        kpd_evt_i,
    input logic        irq_o,
    input logic        evt_hit,
    input logic        clken,
    input logic [15:0] in_sync,
    input logic [1:0]  stat_q
);
    logic dir_wr, stat_rd, stat_kclr, mask_wr;
    assign dir_wr    = bus_sel && bus_wr && (bus_addr == 3'd0);
    assign stat_rd   = bus_sel && !bus_wr && (bus_addr == 3'd5);
    assign stat_kclr = bus_sel && bus_wr && (bus_addr == 3'd5) && bus_wdata[0];
    assign mask_wr   = bus_sel && bus_wr && (bus_addr == 3'd6);

    p_oe_after_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pad_oe == ~$past(bus_wdata)));

    p_frozen_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clken |=> $stable(in_sync));

    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> stat_q[1]);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt_hit) |=> !stat_q[1]);

    p_kpd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !stat_kclr) |=> stat_q[0]);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(kpd_evt_i || evt_hit || mask_wr));
endmodule

bind gpio_evt_top gpio_evt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pad_oe   (pad_oe),
    .kpd_evt_i(kpd_evt_i),
    .irq_o    (irq_o),
    .evt_hit  (evt_hit),
    .clken    (r_q.clken),
    .in_sync  (in_sync),
    .stat_q   (r_q.stat)
);

// File: tb/gpio_evt_top_test.sv
module gpio_evt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        kpd_evt_i = 1'b0;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_evt_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .kpd_evt_i(kpd_evt_i), .irq_o(irq_o)
    );

    // {addr, write value, expected read-back}
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 16'h00F0, 16'h00F0},
        {3'd1, 16'hA5A5, 16'hA5A5},
        {3'd3, 16'hFFFF, 16'h0020},
        {3'd4, 16'hFFFF, 16'h003F},
        {3'd6, 16'hFFFF, 16'h0003},
        {3'd3, 16'h0020, 16'h0020},
        {3'd4, 16'h0000, 16'h0000},
        {3'd6, 16'h0003, 16'h0003}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] v;
        idle(2);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd(3'd0, v); chk("R1 dir", v, 16'hFFFF);
        rd(3'd6, v); chk("R1 mask", v, 16'h0003);
        rd(3'd5, v); chk("R1 status", v, 16'h0000);
        rd(3'd3, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd4, v); chk("R1 evt", v, 16'h0000);
        chk("R1 pad_oe", pad_oe, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0000);

        // R9 write/read-back table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            rd(VEC[i][34:32], v);
            chk("R9 readback", v, VEC[i][15:0]);
        end

        // R2 pad control
        chk("R2 pad_oe", pad_oe, 16'hFF0F);
        chk("R2 pad_out", pad_out, 16'hA5A5);

        // R3 two-edge latency (clock enable is on)
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 3'd2;
        pad_in = 16'h1234;
        @(negedge clk); #1 chk("R3 one edge", bus_rdata, 16'h0000);
        @(negedge clk); #1 chk("R3 two edges", bus_rdata, 16'h1234);
        bus_sel = 0;

        // R4 freeze
        wr(3'd4, 16'h0027);            // enable, pin 3, rising
        wr(3'd3, 16'h0000);
        pad_in = 16'h567F;             // pin 3 goes 0->1
        idle(5);
        rd(3'd2, v); chk("R4 input frozen", v, 16'h1234);
        rd(3'd5, v); chk("R4 no event", v, 16'h0000);
        wr(3'd3, 16'h0020);
        idle(4);
        rd(3'd2, v); chk("R4 resumed", v, 16'h567F);
        rd(3'd5, v); chk("R5 rising pin3", v, 16'h0002);
        rd(3'd5, v); chk("R6 read cleared", v, 16'h0000);

        // R5 falling edge, wrong pin, wrong polarity, disabled
        wr(3'd4, 16'h0007);            // enable, pin 3, falling
        pad_in = 16'h5677;             // pin 3 1->0
        idle(4);
        rd(3'd5, v); chk("R5 falling pin3", v, 16'h0002);
        pad_in = 16'h566F;             // pin 4 1->0, pin 3 0->1
        idle(4);
        rd(3'd5, v); chk("R5 other pin/polarity", v, 16'h0000);
        wr(3'd4, 16'h0006);            // disabled, pin 3, falling
        pad_in = 16'h5667;             // pin 3 1->0
        idle(4);
        rd(3'd5, v); chk("R5 disabled", v, 16'h0000);

        // R8 masking
        wr(3'd4, 16'h0027);            // pin 3 rising
        pad_in = 16'h566F;
        idle(4);
        chk("R8 masked irq", {15'd0, irq_o}, 16'h0000);
        wr(3'd6, 16'h0001);            // unmask GPIO
        #1 chk("R8 unmasked irq", {15'd0, irq_o}, 16'h0001);
        rd(3'd5, v); chk("R8 masked status set", v, 16'h0002);
        #1 chk("R8 irq drop", {15'd0, irq_o}, 16'h0000);

        // R7 keypad
        @(negedge clk); kpd_evt_i = 1;
        @(negedge clk); kpd_evt_i = 0;
        rd(3'd5, v); chk("R7 kpd set", v, 16'h0001);
        rd(3'd5, v); chk("R7 kpd survives read", v, 16'h0001);
        chk("R8 kpd masked", {15'd0, irq_o}, 16'h0000);
        wr(3'd6, 16'h0000);
        #1 chk("R8 kpd irq", {15'd0, irq_o}, 16'h0001);
        wr(3'd5, 16'h0002);
        rd(3'd5, v); chk("R7 bit1 write no effect", v, 16'h0001);
        wr(3'd5, 16'h0001);
        rd(3'd5, v); chk("R7 w1c", v, 16'h0000);
        chk("R8 irq clear", {15'd0, irq_o}, 16'h0000);

        // R6 event coincides with read
        @(negedge clk); pad_in = 16'h5667;  // pin 3 1->0
        @(negedge clk); pad_in = 16'h566F;  // pin 3 0->1 (rising)
        @(negedge clk);
        @(negedge clk);                      // hit is combinational now
        bus_sel = 1; bus_wr = 0; bus_addr = 3'd5;
        #1 chk("R6 pre-read value", bus_rdata, 16'h0000);
        @(negedge clk); bus_sel = 0;
        rd(3'd5, v); chk("R6 event wins", v, 16'h0002);
        rd(3'd5, v); chk("R6 cleared after", v, 16'h0000);

        finish_up();
    end
endmodule